// File: doc/BRIEF.md
# Framed Serial Link Transmitter

This block turns parallel words into frames on a one-bit serial line. A user offers a word through a ready-for-data handshake. At each frame boundary the block raises a one-cycle ready pulse, provided the far end reports a stable lock. If a request is present in that cycle, the word is sent as a data frame or a control frame. If no request is present, an idle filler frame goes out instead, so the line always carries back-to-back frames.

Each frame has a 16-bit or 20-bit payload followed by four coding bits that mark the frame type. Bits are shifted out least significant first, and a two-bit rate select stretches every bit to 1, 2, 4 or 8 clock cycles. The word and the width choice are captured when the frame starts. A start strobe and a frame-type output let surrounding logic follow the frames.

Top module: `serial_frame_tx`

## Requirements
- R1: While `rst_n` is low, `rdy`, `ser_out` and `frame_start` are 0 and `frame_kind` is 0 (idle).
- R2: `rdy` is high for exactly one cycle at each frame boundary, and only if `link_ok` is high in that cycle. Requests are sampled only in a cycle where `rdy` is high; requests in any other cycle have no effect on the frames sent.
- R3: `ctl_req_n` and `dat_req_n` are active low. If both are low in a `rdy` cycle, the frame is a control frame.
- R4: With `wide_sel` = 1 at the boundary, the payload is `word_in[19:0]` and the frame is 24 bit periods long. With `wide_sel` = 0, the payload is `word_in[15:0]` and the frame is 20 bit periods long.
- R5: Serial order is payload bit 0 first, up to the top payload bit, then coding bits C0, C1, C2, C3. C0 is bit 0 of the code value.
- R6: The code value is 4'b1010 for a data frame, 4'b0101 for a control frame and 4'b1100 for an idle frame.
- R7: A boundary with no accepted request sends an idle frame with an all-zero payload. This includes boundaries where `link_ok` is low.
- R8: `rate_sel` = 0, 1, 2 or 3 holds each bit on `ser_out` for 1, 2, 4 or 8 clock cycles.
- R9: Changes on `word_in` or `wide_sel` after a boundary do not alter the frame already in progress.
- R10: `frame_start` pulses for one cycle, in the cycle the first bit of a new frame appears on `ser_out`. From that cycle, `frame_kind` holds the frame's type for the whole frame: 0 idle, 1 data, 2 control.
- R11: The first frame boundary falls on the first bit tick after reset is released. `ser_out` stays 0 until the first frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| link_ok | input | 1 | Remote lock indication; gates the ready pulse |
| ctl_req_n | input | 1 | Active-low control frame request |
| dat_req_n | input | 1 | Active-low data frame request |
| wide_sel | input | 1 | 1 selects a 20-bit payload, 0 a 16-bit payload |
| rate_sel | input | 2 | Bit period of 2**rate_sel clock cycles |
| word_in | input | 20 | Parallel word to send |
| rdy | output | 1 | One-cycle ready-for-data pulse at a frame boundary |
| ser_out | output | 1 | Serial line output |
| frame_start | output | 1 | Strobe marking the first bit of each frame |
| frame_kind | output | 2 | Type of the frame being sent |

## Verification
A behavioural reference model checks every output on every cycle under each of these patterns:
- Held-off requests show the idle filler and the first boundary after reset.
- A data request held low while `word_in` and `wide_sel` change every cycle separates capture at the boundary from live sampling.
- Both requests low together expose the control priority and the two code values.
- Randomly pulsed requests with `link_ok` toggling separate accepted requests from ignored ones.
- The rate select is swept, including changes in the middle of a frame, which tells the bit-period counting apart from the frame-length counting.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    FK_IDLE = 2'd0,
    FK_DATA = 2'd1,
    FK_CTRL = 2'd2
  } frame_kind_e;

  localparam int unsigned TAG_W = 4;
  localparam logic [TAG_W-1:0] TAG_DATA = 4'b1010;
  localparam logic [TAG_W-1:0] TAG_CTRL = 4'b0101;
  localparam logic [TAG_W-1:0] TAG_IDLE = 4'b1100;

endpackage

// File: rtl/stx_rate_div.sv
module stx_rate_div #(
  parameter int unsigned RATE_W = 2,
  localparam int unsigned CNT_W = (1 << RATE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              bit_tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit    = CNT_W'((32'd1 << rate_sel) - 32'd1);
    bit_tick = run && (cnt_q >= limit);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_q >= limit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/stx_frame_build.sv
module stx_frame_build
  import stx_pkg::*;
#(
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned WIDE_W   = 20,
  localparam int unsigned FRAME_MAX = WIDE_W + TAG_W,
  localparam int unsigned LEN_W     = $clog2(FRAME_MAX + 1)
) (
  input  logic [WIDE_W-1:0]    word_in,
  input  logic                 wide_sel,
  input  frame_kind_e          kind,
  output logic [FRAME_MAX-1:0] frame_bits,
  output logic [LEN_W-1:0]     frame_len
);

  logic [WIDE_W-1:0] pay;
  logic              keep;
  logic [TAG_W-1:0]  tag;

  assign keep = (kind != FK_IDLE);

  for (genvar i = 0; i < WIDE_W; i++) begin : g_pay
    if (i < NARROW_W) begin : g_low
      assign pay[i] = keep & word_in[i];
    end else begin : g_high
      assign pay[i] = keep & wide_sel & word_in[i];
    end
  end

  always_comb begin
    unique case (kind)
      FK_DATA: tag = TAG_DATA;
      FK_CTRL: tag = TAG_CTRL;
      default: tag = TAG_IDLE;
    endcase
  end

  always_comb begin
    if (wide_sel) begin
      frame_bits = {tag, pay};
      frame_len  = LEN_W'(WIDE_W + TAG_W);
    end else begin
      frame_bits = FRAME_MAX'({tag, pay[NARROW_W-1:0]});
      frame_len  = LEN_W'(NARROW_W + TAG_W);
    end
  end

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
  parameter int unsigned FRAME_MAX = 24,
  localparam int unsigned LEN_W = $clog2(FRAME_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 shift,
  input  logic [FRAME_MAX-1:0] frame_in,
  input  logic [LEN_W-1:0]     len_in,
  output logic                 ser_out,
  output logic                 last_bit,
  output logic                 primed
);

  logic [FRAME_MAX-1:0] sh_q, sh_d;
  logic [LEN_W-1:0]     idx_q, idx_d;
  logic [LEN_W-1:0]     len_q, len_d;
  logic                 primed_q, primed_d;

  always_comb begin
    sh_d     = sh_q;
    idx_d    = idx_q;
    len_d    = len_q;
    primed_d = primed_q;
    if (load) begin
      sh_d     = frame_in;
      idx_d    = '0;
      len_d    = len_in;
      primed_d = 1'b1;
    end else if (shift) begin
      sh_d  = {1'b0, sh_q[FRAME_MAX-1:1]};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      idx_q    <= '0;
      len_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      idx_q    <= idx_d;
      len_q    <= len_d;
      primed_q <= primed_d;
    end
  end

  assign ser_out  = primed_q & sh_q[0];
  assign last_bit = (idx_q == (len_q - 1'b1));
  assign primed   = primed_q;

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import stx_pkg::*;
#(
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned WIDE_W   = 20,
  parameter int unsigned RATE_W   = 2,
  localparam int unsigned FRAME_MAX = WIDE_W + TAG_W,
  localparam int unsigned LEN_W     = $clog2(FRAME_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_ok,
  input  logic              ctl_req_n,
  input  logic              dat_req_n,
  input  logic              wide_sel,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [WIDE_W-1:0] word_in,
  output logic              rdy,
  output logic              ser_out,
  output logic              frame_start,
  output logic [1:0]        frame_kind
);

  logic                 run_q, run_d;
  logic                 start_q, start_d;
  frame_kind_e          kind_q, kind_d;
  frame_kind_e          kind_sel;
  logic                 bit_tick;
  logic                 last_bit;
  logic                 primed;
  logic                 load;
  logic                 shift;
  logic [FRAME_MAX-1:0] frame_bits;
  logic [LEN_W-1:0]     frame_len;

  stx_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .rate_sel (rate_sel),
    .bit_tick (bit_tick)
  );

  // frame boundary: first tick after reset or tick on the last bit
  always_comb begin
    load  = bit_tick & (~primed | last_bit);
    shift = bit_tick & ~load;
    rdy   = load & link_ok;
    if (rdy && !ctl_req_n) begin
      kind_sel = FK_CTRL;
    end else if (rdy && !dat_req_n) begin
      kind_sel = FK_DATA;
    end else begin
      kind_sel = FK_IDLE;
    end
  end

  stx_frame_build #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_build (
    .word_in    (word_in),
    .wide_sel   (wide_sel),
    .kind       (kind_sel),
    .frame_bits (frame_bits),
    .frame_len  (frame_len)
  );

  stx_shifter #(.FRAME_MAX(FRAME_MAX)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .shift    (shift),
    .frame_in (frame_bits),
    .len_in   (frame_len),
    .ser_out  (ser_out),
    .last_bit (last_bit),
    .primed   (primed)
  );

  always_comb begin
    run_d   = 1'b1;
    start_d = load;
    kind_d  = kind_q;
    if (load) begin
      kind_d = kind_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      start_q <= 1'b0;
      kind_q  <= FK_IDLE;
    end else begin
      run_q   <= run_d;
      start_q <= start_d;
      kind_q  <= kind_d;
    end
  end

  assign frame_start = start_q;
  assign frame_kind  = kind_q;

endmodule

// File: rtl/stx_tx_checker.sv
module stx_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       link_ok,
  input logic       ctl_req_n,
  input logic       dat_req_n,
  input logic       rdy,
  input logic       ser_out,
  input logic       frame_start,
  input logic [1:0] frame_kind,
  input logic       bit_tick
);

  // R1: quiet outputs while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!rdy && !frame_start && frame_kind == 2'd0);
    end
  end

  p_rdy_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> link_ok);

  p_rdy_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);

  p_ctl_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !ctl_req_n) |=> (frame_start && frame_kind == 2'd2));

  p_data_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && ctl_req_n && !dat_req_n) |=> (frame_start && frame_kind == 2'd1));

  p_idle_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && ctl_req_n && dat_req_n) |=> (frame_start && frame_kind == 2'd0));

  p_bit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(ser_out));

  p_kind_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |-> $stable(frame_kind));

endmodule

bind serial_frame_tx stx_tx_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .link_ok     (link_ok),
  .ctl_req_n   (ctl_req_n),
  .dat_req_n   (dat_req_n),
  .rdy         (rdy),
  .ser_out     (ser_out),
  .frame_start (frame_start),
  .frame_kind  (frame_kind),
  .bit_tick    (bit_tick)
);

// File: tb/serial_frame_tx_tb_top.sv
module serial_frame_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        link_ok;
  logic        ctl_req_n;
  logic        dat_req_n;
  logic        wide_sel;
  logic [1:0]  rate_sel;
  logic [19:0] word_in;
  logic        rdy;
  logic        ser_out;
  logic        frame_start;
  logic [1:0]  frame_kind;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // reference model state
  int m_run, m_cnt, m_primed, m_start, m_kind;
  int m_q[$];

  always #10 clk = ~clk;

  serial_frame_tx dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_ok     (link_ok),
    .ctl_req_n   (ctl_req_n),
    .dat_req_n   (dat_req_n),
    .wide_sel    (wide_sel),
    .rate_sel    (rate_sel),
    .word_in     (word_in),
    .rdy         (rdy),
    .ser_out     (ser_out),
    .frame_start (frame_start),
    .frame_kind  (frame_kind)
  );

  task automatic chk(input string tag, input string nm, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s at %0t: got %0d expected %0d", tag, nm, $time, got, exp);
    end
  endtask

  task automatic model_reset();
    m_run = 0; m_cnt = 0; m_primed = 0; m_start = 0; m_kind = 0;
    m_q.delete();
  endtask

  // R5 R6: payload LSB first, then code bits C0..C3
  task automatic model_load(input int kind);
    int w;
    int code;
    w = wide_sel ? 20 : 16;
    code = (kind == 2) ? 5 : (kind == 1) ? 10 : 12;
    m_q.delete();
    for (int i = 0; i < w; i++) m_q.push_back((kind == 0) ? 0 : int'(word_in[i]));
    for (int i = 0; i < 4; i++) m_q.push_back((code >> i) & 1);
    m_kind = kind;
    m_primed = 1;
  endtask

  task automatic check_and_advance(input string tag);
    int lim, tick, bnd, e_rdy, e_ser, kind;
    lim   = (1 << rate_sel) - 1;
    tick  = (m_run != 0 && m_cnt >= lim) ? 1 : 0;
    bnd   = (tick != 0 && (m_primed == 0 || m_q.size() == 1)) ? 1 : 0;
    e_rdy = (bnd != 0 && link_ok) ? 1 : 0;
    e_ser = (m_primed != 0) ? m_q[0] : 0;
    chk(tag, "rdy", int'(rdy), e_rdy);
    chk(tag, "ser_out", int'(ser_out), e_ser);
    chk(tag, "frame_start", int'(frame_start), m_start);
    chk(tag, "frame_kind", int'(frame_kind), m_kind);
    if (!rst_n) begin
      model_reset();
    end else begin
      if (bnd != 0) begin
        kind = (e_rdy != 0 && !ctl_req_n) ? 2 : (e_rdy != 0 && !dat_req_n) ? 1 : 0;
        model_load(kind);
      end else if (tick != 0) begin
        void'(m_q.pop_front());
      end
      m_start = bnd;
      if (m_run == 0 || tick != 0) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      m_run = 1;
    end
  endtask

  task automatic cyc(input string tag);
    #1;
    check_and_advance(tag);
  endtask

  initial begin
    rst_n = 1'b0; link_ok = 1'b0; ctl_req_n = 1'b1; dat_req_n = 1'b1;
    wide_sel = 1'b0; rate_sel = 2'd0; word_in = '0;
    model_reset();
    // R1: reset held
    for (int n = 0; n < 6; n++) begin
      @(negedge clk); link_ok = 1'b1; ctl_req_n = 1'b0; word_in = 20'(n * 977); cyc("R1");
    end
    // R11: release, no requests, first boundary and idle output
    for (int n = 0; n < 50; n++) begin
      @(negedge clk); rst_n = 1'b1; ctl_req_n = 1'b1; dat_req_n = 1'b1; cyc("R11");
    end
    // R7: idle frames with words present but no request
    for (int n = 0; n < 60; n++) begin
      @(negedge clk); word_in = 20'($urandom); cyc("R7");
    end
    // R5: data held, narrow, word changing every cycle
    for (int n = 0; n < 120; n++) begin
      @(negedge clk); dat_req_n = 1'b0; word_in = 20'($urandom); cyc("R5");
    end
    // R9: width select and word change mid-frame
    for (int n = 0; n < 160; n++) begin
      @(negedge clk); wide_sel = 1'($urandom); word_in = 20'($urandom); cyc("R9");
    end
    // R4: wide payload at half rate
    for (int n = 0; n < 150; n++) begin
      @(negedge clk); wide_sel = 1'b1; rate_sel = 2'd1; word_in = 20'($urandom); cyc("R4");
    end
    // R3: both requests low -> control frames
    for (int n = 0; n < 250; n++) begin
      @(negedge clk); rate_sel = 2'd2; ctl_req_n = 1'b0; dat_req_n = 1'b0;
      word_in = 20'($urandom); cyc("R3");
    end
    // R6: mixed control and data frames
    for (int n = 0; n < 200; n++) begin
      @(negedge clk); rate_sel = 2'd0; ctl_req_n = 1'($urandom); dat_req_n = 1'($urandom);
      wide_sel = 1'($urandom); word_in = 20'($urandom); cyc("R6");
    end
    // R2: link low, then toggling link with pulsed requests
    for (int n = 0; n < 120; n++) begin
      @(negedge clk); link_ok = 1'b0; ctl_req_n = 1'($urandom); dat_req_n = 1'b0; cyc("R2");
    end
    for (int n = 0; n < 300; n++) begin
      @(negedge clk); link_ok = 1'($urandom); ctl_req_n = 1'($urandom); dat_req_n = 1'($urandom);
      word_in = 20'($urandom); cyc("R2");
    end
    // R8: slowest rate, then rate changing mid-frame
    for (int n = 0; n < 500; n++) begin
      @(negedge clk); link_ok = 1'b1; rate_sel = 2'd3; ctl_req_n = 1'b1;
      dat_req_n = 1'($urandom); word_in = 20'($urandom); cyc("R8");
    end
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      if (n % 37 == 0) rate_sel = 2'($urandom);
      dat_req_n = 1'($urandom); word_in = 20'($urandom); cyc("R8");
    end
    // R10: everything random
    for (int n = 0; n < 300; n++) begin
      @(negedge clk); link_ok = 1'($urandom); ctl_req_n = 1'($urandom); dat_req_n = 1'($urandom);
      wide_sel = 1'($urandom); rate_sel = 2'($urandom); word_in = 20'($urandom); cyc("R10");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got 0 expected 1 completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule